// File: doc/BRIEF.md
# Instruction Prefetch Control Machine

This block sits in front of an instruction fetch unit and decides, cycle by cycle, which line the unit should ask the memory subsystem for next, if any. It looks up four addresses in a small direct-mapped tag store:
- the current program counter;
- the address two bytes past it, which holds the second half of a 32-bit instruction that runs over a line boundary;
- the sequential lookahead address, PC+8;
- the target of a pending control-flow discontinuity.

The lookup results, the state of a bounded prefetch queue and a few flags from the decode side yield one of twelve condition codes. The code is output for tracing and also chooses whether a line request goes out.

A chosen request is registered and then presented on a valid/ready interface. It stays on that interface until it is accepted. A retry from memory cancels the attempt, and the same address is shown again on the following cycle. An accepted request records its line in the tag store, so later lookups of that line hit. Acceptance also adds one to the queue occupancy, and each pop from the decoder removes one. Each line slot can be marked unavailable by an input vector. The block will not prefetch into a slot that is marked unavailable.

The controller has two states:
- FS_SELECT: the condition is evaluated.
- FS_ISSUE: a request is on the bus.

It has three transitions:
- FS_SELECT to FS_ISSUE when the condition calls for a fetch.
- FS_ISSUE to FS_SELECT on acceptance.
- FS_ISSUE to itself while the request waits or is retried.

Top module: `ifetch_pf_ctrl`

## Requirements
- R1: After reset, req_valid_o is 0, cond_o is 0, pq_count_o is 0 and every tag slot is empty, so every lookup misses.
- R2: In FS_SELECT with fetch_en_i low, cond_o is 0 (idle) and no request starts. Idle takes priority over every other condition.
- R3: In FS_SELECT with pq_count_o equal to QDEPTH, cond_o is 1 (stall) and no request starts. pq_count_o never exceeds QDEPTH. The order of the remaining checks is: discontinuity, PC miss, straddle miss, mid-instruction, lookahead.
- R4: In FS_ISSUE, req_valid_o is 1 and req_addr_o is held. A request is accepted on a cycle with req_ready_i high and mem_retry_i low. On a cycle with mem_retry_i high, cond_o is 1 and the request is not accepted. On the next cycle the same address is presented again. Otherwise, cond_o keeps the code that started the request.
- R5: pq_count_o rises by one on acceptance and falls by one when pq_pop_i is high and the count is non-zero. A pop at zero is ignored. Acceptance and a pop in the same cycle leave the count unchanged.
- R6: A miss on the current PC gives cond_o 4 and a request for the line holding the PC. Request addresses are always line-aligned: the low log2(LINE_B) bits are 0.
- R7: With pc_straddle_i high, a PC hit and a miss at PC+2, cond_o is 3 and the line holding PC+2 is requested.
- R8: With pc_mid_i high and no higher condition, cond_o is 2 and no request starts.
- R9: When the PC hits and no higher condition applies, the result depends on the line holding PC+8:
  - if that line hits, cond_o is 5 and no request starts;
  - if it misses and its slot is available, cond_o is 6 and that line is requested;
  - if it misses and its slot is unavailable, cond_o is 7 and no request starts.
- R10: With disc_req_i high and disc_tgt_ok_i low, cond_o is 8 and no request starts.
- R11: With disc_req_i and disc_tgt_ok_i both high, the result depends on the target's line:
  - if it hits, cond_o is 9 and no request starts;
  - if it misses and its slot is available, cond_o is 10 and the target line is requested;
  - if it misses and its slot is unavailable, cond_o is 11 and no request starts.
- R12: A line's slot index is address bits [log2(LINE_B) +: log2(NLINES)], and line_busy_i[index] marks that slot unavailable. An accepted request writes its tag into that slot, so lookups of that line hit from the next cycle on, until another line with the same index is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en_i | input | 1 | Fetch enable; low gives the idle condition |
| cur_pc_i | input | AW | Current program counter |
| pc_mid_i | input | 1 | PC points into the second half of a 32-bit instruction |
| pc_straddle_i | input | 1 | Instruction at PC runs over a line boundary |
| disc_req_i | input | 1 | A discontinuity is pending |
| disc_tgt_ok_i | input | 1 | Discontinuity target is known (immediate form) |
| disc_tgt_i | input | AW | Discontinuity target address |
| line_busy_i | input | NLINES | Per-slot unavailable marks |
| req_valid_o | output | 1 | Line request valid |
| req_addr_o | output | AW | Line-aligned request address |
| req_ready_i | input | 1 | Memory accepts the request |
| mem_retry_i | input | 1 | Memory cancels the current attempt |
| pq_pop_i | input | 1 | Decoder consumes one queue entry |
| pq_count_o | output | OCC_W | Prefetch queue occupancy |
| cond_o | output | 4 | Condition code for tracing |

## Verification
The assertions rely on these input conditions:
- All inputs hold known values from reset on.
- req_ready_i and mem_retry_i may toggle freely, whether or not a request is shown.
- pq_pop_i may be asserted at any count, because the block must ignore pops at zero.

The stimulus draws program counters and targets from a window of 64 lines over 16 slots, so hits, misses and slot conflicts all happen often. It also toggles the unavailable marks, retry and ready at random. These draws stay within the conditions above.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [3:0] {
        PFC_IDLE          = 4'd0,
        PFC_STALL         = 4'd1,
        PFC_MIDWORD       = 4'd2,
        PFC_SPLIT_MISS    = 4'd3,
        PFC_PC_MISS       = 4'd4,
        PFC_AHEAD_HIT     = 4'd5,
        PFC_AHEAD_FETCH   = 4'd6,
        PFC_AHEAD_BLOCKED = 4'd7,
        PFC_BR_HOLD       = 4'd8,
        PFC_BR_HIT        = 4'd9,
        PFC_BR_FETCH      = 4'd10,
        PFC_BR_BLOCKED    = 4'd11
    } pf_cond_e;

    typedef enum logic {
        FS_SELECT = 1'b0,
        FS_ISSUE  = 1'b1
    } pf_state_e;

    // lookup port numbering
    localparam int unsigned LK_PC    = 0;
    localparam int unsigned LK_SPLIT = 1;
    localparam int unsigned LK_AHEAD = 2;
    localparam int unsigned LK_BR    = 3;
    localparam int unsigned LK_NUM   = 4;

endpackage

// File: rtl/pfc_tag_lookup.sv
module pfc_tag_lookup #(
    parameter int unsigned AW     = 32,
    parameter int unsigned LINE_B = 16,
    parameter int unsigned NLINES = 16,
    parameter int unsigned NPORT  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0][AW-1:0]   lk_addr_i,
    output logic [NPORT-1:0]           lk_hit_o,
    output logic [NPORT-1:0]           lk_busy_o,
    input  logic [NLINES-1:0]          line_busy_i,
    input  logic                       ins_en_i,
    input  logic [AW-1:0]              ins_addr_i
);
    localparam int unsigned OFF_W = $clog2(LINE_B);
    localparam int unsigned IDX_W = $clog2(NLINES);
    localparam int unsigned TAG_W = AW - OFF_W - IDX_W;

    logic [NLINES-1:0] vld_q;
    logic [TAG_W-1:0]  tag_q [NLINES];
    logic [IDX_W-1:0]  ins_idx;
    logic [TAG_W-1:0]  ins_tag;

    assign ins_idx = ins_addr_i[OFF_W +: IDX_W];
    assign ins_tag = ins_addr_i[AW-1 -: TAG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (ins_en_i) begin
            vld_q[ins_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en_i) begin
            tag_q[ins_idx] <= ins_tag;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [IDX_W-1:0] p_idx;
        logic [TAG_W-1:0] p_tag;
        assign p_idx        = lk_addr_i[p][OFF_W +: IDX_W];
        assign p_tag        = lk_addr_i[p][AW-1 -: TAG_W];
        assign lk_hit_o[p]  = vld_q[p_idx] && (tag_q[p_idx] == p_tag);
        assign lk_busy_o[p] = line_busy_i[p_idx];
    end

    AST_INSTALL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en_i |=> vld_q[$past(ins_idx)] && (tag_q[$past(ins_idx)] == $past(ins_tag))); // R12

endmodule

// File: rtl/pfc_pq_count.sv
module pfc_pq_count #(
    parameter int unsigned QDEPTH = 4,
    localparam int unsigned OCC_W = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [OCC_W-1:0] count_o,
    output logic             full_o
);
    logic [OCC_W-1:0] cnt_q;
    logic             do_pop;

    assign do_pop = pop_i && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({push_i, do_pop})
                2'b10:   cnt_q <= cnt_q + OCC_W'(1);
                2'b01:   cnt_q <= cnt_q - OCC_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
    assign full_o  = (cnt_q == OCC_W'(QDEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= OCC_W'(QDEPTH)); // R3
    AST_POP_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) && !push_i |=> cnt_q == '0); // R5
    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !pop_i |=> cnt_q == $past(cnt_q) + OCC_W'(1)); // R5

endmodule

// File: rtl/pfc_cond_sel.sv
module pfc_cond_sel
    import pfc_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned LINE_B = 16
) (
    input  logic                    fetch_en_i,
    input  logic                    q_full_i,
    input  logic                    disc_req_i,
    input  logic                    disc_tgt_ok_i,
    input  logic                    pc_mid_i,
    input  logic                    pc_straddle_i,
    input  logic [LK_NUM-1:0]       hit_i,
    input  logic [LK_NUM-1:0]       busy_i,
    input  logic [LK_NUM-1:0][AW-1:0] addr_i,
    output pf_cond_e                cond_o,
    output logic                    want_req_o,
    output logic [AW-1:0]           line_o
);
    localparam int unsigned OFF_W = $clog2(LINE_B);

    logic [AW-1:0] pick_addr;

    always_comb begin
        cond_o    = PFC_IDLE;
        pick_addr = addr_i[LK_PC];
        if (!fetch_en_i) begin
            cond_o = PFC_IDLE;
        end else if (q_full_i) begin
            cond_o = PFC_STALL;
        end else if (disc_req_i) begin
            pick_addr = addr_i[LK_BR];
            if (!disc_tgt_ok_i)       cond_o = PFC_BR_HOLD;
            else if (hit_i[LK_BR])    cond_o = PFC_BR_HIT;
            else if (busy_i[LK_BR])   cond_o = PFC_BR_BLOCKED;
            else                      cond_o = PFC_BR_FETCH;
        end else if (!hit_i[LK_PC]) begin
            cond_o = PFC_PC_MISS;
        end else if (pc_straddle_i && !hit_i[LK_SPLIT]) begin
            cond_o    = PFC_SPLIT_MISS;
            pick_addr = addr_i[LK_SPLIT];
        end else if (pc_mid_i) begin
            cond_o = PFC_MIDWORD;
        end else begin
            pick_addr = addr_i[LK_AHEAD];
            if (hit_i[LK_AHEAD])       cond_o = PFC_AHEAD_HIT;
            else if (busy_i[LK_AHEAD]) cond_o = PFC_AHEAD_BLOCKED;
            else                       cond_o = PFC_AHEAD_FETCH;
        end
    end

    always_comb begin
        unique case (cond_o)
            PFC_PC_MISS, PFC_SPLIT_MISS,
            PFC_AHEAD_FETCH, PFC_BR_FETCH: want_req_o = 1'b1;
            default:                       want_req_o = 1'b0;
        endcase
    end

    assign line_o = {pick_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/ifetch_pf_ctrl.sv
module ifetch_pf_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned LINE_B = 16,
    parameter int unsigned NLINES = 16,
    parameter int unsigned QDEPTH = 4,
    localparam int unsigned OCC_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en_i,
    input  logic [AW-1:0]     cur_pc_i,
    input  logic              pc_mid_i,
    input  logic              pc_straddle_i,
    input  logic              disc_req_i,
    input  logic              disc_tgt_ok_i,
    input  logic [AW-1:0]     disc_tgt_i,
    input  logic [NLINES-1:0] line_busy_i,
    output logic              req_valid_o,
    output logic [AW-1:0]     req_addr_o,
    input  logic              req_ready_i,
    input  logic              mem_retry_i,
    input  logic              pq_pop_i,
    output logic [OCC_W-1:0]  pq_count_o,
    output logic [3:0]        cond_o
);
    localparam int unsigned OFF_W = $clog2(LINE_B);

    pf_state_e                 state_q, state_d;
    logic [AW-1:0]             hold_addr_q;
    pf_cond_e                  hold_cond_q;
    logic [LK_NUM-1:0][AW-1:0] lk_addr;
    logic [LK_NUM-1:0]         lk_hit, lk_busy;
    pf_cond_e                  sel_cond;
    logic                      sel_req;
    logic [AW-1:0]             sel_line;
    logic                      q_full;
    logic                      accept;

    assign lk_addr[LK_PC]    = cur_pc_i;
    assign lk_addr[LK_SPLIT] = cur_pc_i + AW'(2);
    assign lk_addr[LK_AHEAD] = cur_pc_i + AW'(8);
    assign lk_addr[LK_BR]    = disc_tgt_i;

    pfc_tag_lookup #(.AW(AW), .LINE_B(LINE_B), .NLINES(NLINES), .NPORT(LK_NUM)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr_i  (lk_addr),
        .lk_hit_o   (lk_hit),
        .lk_busy_o  (lk_busy),
        .line_busy_i(line_busy_i),
        .ins_en_i   (accept),
        .ins_addr_i (hold_addr_q)
    );

    pfc_cond_sel #(.AW(AW), .LINE_B(LINE_B)) u_sel (
        .fetch_en_i   (fetch_en_i),
        .q_full_i     (q_full),
        .disc_req_i   (disc_req_i),
        .disc_tgt_ok_i(disc_tgt_ok_i),
        .pc_mid_i     (pc_mid_i),
        .pc_straddle_i(pc_straddle_i),
        .hit_i        (lk_hit),
        .busy_i       (lk_busy),
        .addr_i       (lk_addr),
        .cond_o       (sel_cond),
        .want_req_o   (sel_req),
        .line_o       (sel_line)
    );

    pfc_pq_count #(.QDEPTH(QDEPTH)) u_pq (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (accept),
        .pop_i  (pq_pop_i),
        .count_o(pq_count_o),
        .full_o (q_full)
    );

    assign accept = (state_q == FS_ISSUE) && req_ready_i && !mem_retry_i;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_SELECT: if (sel_req) state_d = FS_ISSUE;
            FS_ISSUE:  if (accept)  state_d = FS_SELECT;
            default:                state_d = FS_SELECT;
        endcase
    end

    // state register and held request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= FS_SELECT;
            hold_addr_q <= '0;
            hold_cond_q <= PFC_IDLE;
        end else begin
            state_q <= state_d;
            if ((state_q == FS_SELECT) && sel_req) begin
                hold_addr_q <= sel_line;
                hold_cond_q <= sel_cond;
            end
        end
    end

    // outputs
    always_comb begin
        req_valid_o = 1'b0;
        req_addr_o  = hold_addr_q;
        cond_o      = sel_cond;
        unique case (state_q)
            FS_SELECT: begin
                req_valid_o = 1'b0;
                cond_o      = sel_cond;
            end
            FS_ISSUE: begin
                req_valid_o = 1'b1;
                cond_o      = mem_retry_i ? PFC_STALL : hold_cond_q;
            end
            default: ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !(req_ready_i && !mem_retry_i) |=> req_valid_o && $stable(req_addr_o)); // R4
    AST_RETRY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && mem_retry_i |-> cond_o == 4'd1); // R4
    AST_NO_REQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_o && (pq_count_o == OCC_W'(QDEPTH)) |=> !req_valid_o); // R3
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_o && !fetch_en_i |-> cond_o == 4'd0 ##1 !req_valid_o); // R2
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> req_addr_o[OFF_W-1:0] == '0); // R6

endmodule

// File: tb/ifetch_pf_ctrl_tb_top.sv
module ifetch_pf_ctrl_tb_top;
    localparam int AW = 32, LINE_B = 16, NLINES = 16, QDEPTH = 4;
    localparam int OCC_W = $clog2(QDEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_en, pc_mid, pc_strad, disc_req, disc_ok, ready, retry, pop;
    logic [AW-1:0] pc, tgt, req_addr;
    logic [NLINES-1:0] busy;
    logic req_valid;
    logic [OCC_W-1:0] cnt;
    logic [3:0] cond;

    always #4 clk = ~clk;

    ifetch_pf_ctrl #(.AW(AW), .LINE_B(LINE_B), .NLINES(NLINES), .QDEPTH(QDEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_en_i(fetch_en), .cur_pc_i(pc), .pc_mid_i(pc_mid),
        .pc_straddle_i(pc_strad), .disc_req_i(disc_req), .disc_tgt_ok_i(disc_ok),
        .disc_tgt_i(tgt), .line_busy_i(busy), .req_valid_o(req_valid), .req_addr_o(req_addr),
        .req_ready_i(ready), .mem_retry_i(retry), .pq_pop_i(pop), .pq_count_o(cnt), .cond_o(cond));

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference
    bit m_vld [NLINES];
    int unsigned m_tag [NLINES];
    bit m_iss;
    int unsigned m_addr;
    int m_cond, m_occ;

    function automatic bit m_hit(int unsigned a);
        return m_vld[(a / LINE_B) % NLINES] && m_tag[(a / LINE_B) % NLINES] == a / (LINE_B * NLINES);
    endfunction
    function automatic bit m_busy(int unsigned a);
        return busy[(a / LINE_B) % NLINES];
    endfunction
    function automatic int unsigned lalign(int unsigned a);
        return a - (a % LINE_B);
    endfunction

    function automatic int pick(output int unsigned line);
        line = lalign(pc);
        if (!fetch_en) return 0;
        if (m_occ == QDEPTH) return 1;
        if (disc_req) begin
            line = lalign(tgt);
            if (!disc_ok) return 8;
            if (m_hit(tgt)) return 9;
            return m_busy(tgt) ? 11 : 10;
        end
        if (!m_hit(pc)) return 4;
        if (pc_strad && !m_hit(pc + 2)) begin line = lalign(pc + 2); return 3; end
        if (pc_mid) return 2;
        line = lalign(pc + 8);
        if (m_hit(pc + 8)) return 5;
        return m_busy(pc + 8) ? 7 : 6;
    endfunction

    function automatic string rq(int c);
        case (c)
            0: return "R2";   1: return "R3";   2: return "R8";   3: return "R7";
            4: return "R6";   5, 6, 7: return "R9";  8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic fail(string r, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    endtask

    // one cycle: inputs already driven at the falling edge
    task automatic step(int dir_cond = -1, string dir_tag = "");
        int unsigned ln;
        int c, ec;
        #1;
        c = pick(ln);
        ec = m_iss ? (retry ? 1 : m_cond) : c;
        n_chk++;
        if (int'(cond) != ec) fail(m_iss ? "R4" : rq(ec), "cond", cond, ec);
        n_chk++;
        if (req_valid != m_iss) fail("R4", "req_valid", req_valid, m_iss);
        if (m_iss) begin
            n_chk++;
            if (req_addr != m_addr) fail("R4", "req_addr", req_addr, m_addr);
        end
        n_chk++;
        if (int'(cnt) != m_occ) fail("R5", "count", cnt, m_occ);
        if (dir_cond >= 0) begin
            n_chk++;
            if (int'(cond) != dir_cond) fail(dir_tag, "directed cond", cond, dir_cond);
        end
        @(posedge clk);
        begin
            bit acc = m_iss && ready && !retry;
            if (acc) begin
                m_vld[(m_addr / LINE_B) % NLINES] = 1;
                m_tag[(m_addr / LINE_B) % NLINES] = m_addr / (LINE_B * NLINES);
                m_iss = 0;
            end else if (!m_iss && (c == 3 || c == 4 || c == 6 || c == 10)) begin
                m_iss = 1; m_addr = ln; m_cond = c;
            end
            if (acc && !(pop && m_occ > 0)) m_occ++;
            else if (!acc && pop && m_occ > 0) m_occ--;
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        fetch_en = 1; pc_mid = 0; pc_strad = 0; disc_req = 0; disc_ok = 0;
        ready = 1; retry = 0; pop = 0; busy = '0; pc = 32'h100; tgt = 32'h0;
    endtask

    initial begin
        #160000;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_in();
        fetch_en = 0;
        foreach (m_vld[i]) m_vld[i] = 0;
        m_iss = 0; m_occ = 0; m_cond = 0; m_addr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        n_chk++; if (req_valid !== 1'b0) fail("R1", "req_valid", req_valid, 0);
        n_chk++; if (cond !== 4'd0) fail("R1", "cond", cond, 0);
        n_chk++; if (cnt !== '0) fail("R1", "count", cnt, 0);
        rst_n = 1;
        @(negedge clk);
        step(0, "R2");                                   // disabled
        fetch_en = 1;
        step(4, "R6");                                   // empty tags: PC miss (R1)
        step(4, "R4");                                   // issue, accepted
        step(5, "R12");                                  // line 0x100 now present
        pc = 32'h10C; busy[1] = 1;
        step(7, "R9");                                   // PC+8 slot unavailable
        busy[1] = 0;
        step(6, "R9"); step(6, "R4");
        pc = 32'h11E; pc_strad = 1;
        step(3, "R7"); step(3, "R4");
        pc_strad = 0; pc_mid = 1;
        step(2, "R8");
        pc_mid = 0; disc_req = 1;
        step(8, "R10");
        disc_ok = 1; tgt = 32'h104;
        step(9, "R11");
        tgt = 32'h200; busy[0] = 1;
        step(11, "R11");
        busy[0] = 0;
        step(10, "R11");
        ready = 0; retry = 1; step(1, "R4");
        retry = 0;            step(10, "R4");
        ready = 1;            step(10, "R4");           // fourth entry
        disc_req = 0; pc = 32'h100;
        step(1, "R3");                                   // full
        pop = 1; step(1, "R3");
        pop = 0; step(4, "R6");                          // 0x100 evicted by 0x200
        step(4, "R4");
        pop = 1; fetch_en = 0;
        repeat (6) step(0, "R5");                        // drains, pops at zero ignored
        // random phase
        for (int i = 0; i < 4000; i++) begin
            fetch_en = ($urandom_range(0, 9) != 0);
            pc       = $urandom_range(0, 511) * 2;
            tgt      = $urandom_range(0, 511) * 2;
            disc_req = ($urandom_range(0, 4) == 0);
            disc_ok  = ($urandom_range(0, 9) < 7);
            pc_strad = ($urandom_range(0, 6) == 0);
            pc_mid   = ($urandom_range(0, 9) == 0);
            ready    = ($urandom_range(0, 9) < 7);
            retry    = ($urandom_range(0, 6) == 0);
            pop      = ($urandom_range(0, 9) < 3);
            for (int b = 0; b < NLINES; b++) busy[b] = ($urandom_range(0, 3) == 0);
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule